// File: doc/BRIEF.md
# Interrupt Redirection Controller

This block routes interrupt events from a set of numbered input lines to a delivery request. Each line owns a programmable routing entry. The entry holds a vector, a delivery mode, a destination interpretation, a mask bit and a destination. When an event arrives on a line, the block reads that line's entry. A masked line produces nothing. An entry with a legal mode produces a delivery request one cycle later. An entry with a reserved mode produces an error pulse and no request.

Software reaches every internal register through a 32-bit slave port that exposes only two word locations. The word at byte offset 0 holds a register select value. The word at byte offset 16 is a data window onto the register that the select value names. The selectable registers are:

- an identification register;
- a read-only version word;
- an arbitration identifier;
- the routing table. Each 64-bit entry occupies two consecutive select values.

Top module: `irq_route_ctl`

## Requirements
- R1: Only byte offsets 0 (select) and 16 (data window) are legal. Every bus access raises `rdValid` one cycle later if it is a read. An access at any other offset raises `accessErr` one cycle later, reads as zero and changes no register.
- R2: A write at offset 0 stores bits 7:0 of the write data as the select value. A read at offset 0 returns that value with bits 31:8 zero. The select value is 0 after reset.
- R3: Select 0x00 is the identification register, a 4-bit field in bits 27:24. Writes update it, and reads return it with all other bits zero. It resets to `RESET_ID`.
- R4: Select 0x01 is read only and ignores writes. Reads return (NUM_LINES-1) in bits 23:16 and the version constant 0x11 in bits 7:0. All other bits read as zero.
- R5: Select 0x02 is the arbitration identifier in bits 27:24. It resets to the same value as the identification register and is written independently of it.
- R6: The low half of entry n sits at select 0x10+2n, and the high half at 0x11+2n. Low-half fields are vector [7:0], delivery mode [10:8], destination mode [11] and mask [16]. The destination sits in bits [31:24] of the high half. A write to either half zeroes that half's other bits, so they always read as zero.
- R7: After reset every routing entry reads as zero in both halves.
- R8: A data-window access whose select value names no register raises `decodeErr` one cycle later. A read of such a select returns zero. A write to it changes no register.
- R9: When `irqValid` is sampled with an unmasked line whose mode is legal, `reqValid` pulses in the next cycle. The pulse carries that line's vector, mode, destination mode and destination. Legal modes are 0 fixed, 1 lowest priority, 2 system management, 4 non-maskable, 5 init and 7 external. Destination mode 0 names one physical target and destination mode 1 names a bitmask of logical targets; both are passed through unchanged.
- R10: An event on a line whose mask bit is 1 produces neither `reqValid` nor `modeErr`, whatever its mode.
- R11: An event on an unmasked line with mode 3 or 6 pulses `modeErr` in the next cycle and does not raise `reqValid`.
- R12: An event whose line index is NUM_LINES or more produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Bus access strobe, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 5 | Byte offset of the access |
| busWdata | input | 32 | Write data |
| rdValid | output | 1 | Read data valid, one cycle after a read |
| rdData | output | 32 | Read data |
| accessErr | output | 1 | Illegal offset pulse |
| decodeErr | output | 1 | Undefined select pulse |
| irqValid | input | 1 | Interrupt event strobe |
| irqIndex | input | 5 | Line number of the event |
| reqValid | output | 1 | Delivery request pulse |
| reqVector | output | 8 | Request vector |
| reqMode | output | 3 | Request delivery mode |
| reqDestMode | output | 1 | 0 = physical, 1 = logical bitmask |
| reqDest | output | 8 | Request destination |
| modeErr | output | 1 | Reserved delivery mode pulse |

## Verification
Register writes take effect at the clock edge that samples them, so a read issued on the following cycle already sees the new value. Read data, `rdValid`, `accessErr` and `decodeErr` are registered and appear one cycle after the access is sampled. `reqValid`, the request fields and `modeErr` likewise appear one cycle after the event is sampled. The bench drives each stimulus on a falling edge and holds it through one rising edge. It samples the outputs shortly after that edge, then withdraws the stimulus. Every result is therefore compared in exactly the cycle it is due.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam logic [7:0] VERSION = 8'h11;
  localparam logic [7:0] SEL_ID = 8'h00;
  localparam logic [7:0] SEL_VER = 8'h01;
  localparam logic [7:0] SEL_ARB = 8'h02;
  localparam logic [7:0] SEL_TABLE = 8'h10;

  typedef enum logic [2:0] {
    SRC_ZERO,
    SRC_SEL,
    SRC_ID,
    SRC_VER,
    SRC_ARB,
    SRC_LOW,
    SRC_HIGH
  } rd_src_e;

  typedef struct packed {
    logic wrId;
    logic wrArb;
    logic wrLow;
    logic wrHigh;
    logic rdEn;
    rd_src_e rdSrc;
    logic [6:0] idx;
  } ctl_strobe_t;

  typedef struct packed {
    logic [7:0] dest;
    logic mask;
    logic destMode;
    logic [2:0] mode;
    logic [7:0] vector;
  } route_entry_t;

endpackage

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int NUM_LINES = 24,
  parameter int ADDR_W = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic busValid,
  input  logic busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0] busWdata,
  output logic [7:0] selReg,
  output ctl_strobe_t strb,
  output logic rdValid,
  output logic accessErr,
  output logic decodeErr
);

  localparam int TABLE_END = 16 + 2 * NUM_LINES;

  logic atSel, atWin, isId, isVer, isArb, isEnt, known;
  logic winWr;
  logic [7:0] entOff;

  always_comb begin
    atSel = busAddr == ADDR_W'(0);
    atWin = busAddr == ADDR_W'(16);
    isId = selReg == SEL_ID;
    isVer = selReg == SEL_VER;
    isArb = selReg == SEL_ARB;
    isEnt = (32'(selReg) >= 16) && (32'(selReg) < TABLE_END);
    known = isId | isVer | isArb | isEnt;
    entOff = selReg - SEL_TABLE;
    winWr = busValid && busWrite && atWin;
  end

  always_comb begin
    strb.wrId = winWr && isId;
    strb.wrArb = winWr && isArb;
    strb.wrLow = winWr && isEnt && !selReg[0];
    strb.wrHigh = winWr && isEnt && selReg[0];
    strb.rdEn = busValid && !busWrite;
    strb.idx = entOff[7:1];
    strb.rdSrc = SRC_ZERO;
    if (atSel) strb.rdSrc = SRC_SEL;
    else if (atWin) begin
      if (isId) strb.rdSrc = SRC_ID;
      else if (isVer) strb.rdSrc = SRC_VER;
      else if (isArb) strb.rdSrc = SRC_ARB;
      else if (isEnt) strb.rdSrc = selReg[0] ? SRC_HIGH : SRC_LOW;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selReg <= '0;
      rdValid <= 1'b0;
      accessErr <= 1'b0;
      decodeErr <= 1'b0;
    end else begin
      if (busValid && busWrite && atSel) selReg <= busWdata[7:0];
      rdValid <= busValid && !busWrite;
      accessErr <= busValid && !(atSel || atWin);
      decodeErr <= busValid && atWin && !known;
    end
  end

  // R2: the select value loads from the bus at offset 0
  assert_sel_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    busValid && busWrite && atSel |=> selReg == $past(busWdata[7:0]));

  // R1: no access other than a select write moves the select value
  assert_sel_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(busValid && busWrite && atSel) |=> $stable(selReg));

  // R8: the two error kinds are never raised together
  assert_err_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(accessErr && decodeErr));

endmodule

// File: rtl/irq_route_dp.sv
module irq_route_dp
  import irq_route_pkg::*;
#(
  parameter int NUM_LINES = 24,
  parameter logic [3:0] RESET_ID = 4'h2,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic clk,
  input  logic rstN,
  input  ctl_strobe_t strb,
  input  logic [7:0] selReg,
  input  logic [31:0] busWdata,
  output logic [31:0] rdData,
  input  logic irqValid,
  input  logic [IDX_W-1:0] irqIndex,
  output logic reqValid,
  output logic [7:0] reqVector,
  output logic [2:0] reqMode,
  output logic reqDestMode,
  output logic [7:0] reqDest,
  output logic modeErr
);

  route_entry_t routeTable [NUM_LINES];
  logic [3:0] idReg, arbReg;
  logic [IDX_W-1:0] tIdx;
  route_entry_t rdEntry, irqEntry;
  logic irqInRange, modeReserved, irqLive;
  logic [31:0] rdWord;

  assign tIdx = strb.idx[IDX_W-1:0];

  always_comb begin
    rdEntry = routeTable[tIdx];
    irqInRange = 32'(irqIndex) < NUM_LINES;
    irqEntry = irqInRange ? routeTable[irqIndex] : '0;
    modeReserved = (irqEntry.mode == 3'd3) || (irqEntry.mode == 3'd6);
    irqLive = irqValid && irqInRange && !irqEntry.mask;
  end

  always_comb begin
    unique case (strb.rdSrc)
      SRC_SEL: rdWord = {24'h0, selReg};
      SRC_ID: rdWord = {4'h0, idReg, 24'h0};
      SRC_VER: rdWord = {8'h0, 8'(NUM_LINES - 1), 8'h0, VERSION};
      SRC_ARB: rdWord = {4'h0, arbReg, 24'h0};
      SRC_LOW: rdWord = {15'h0, rdEntry.mask, 4'h0, rdEntry.destMode,
                         rdEntry.mode, rdEntry.vector};
      SRC_HIGH: rdWord = {rdEntry.dest, 24'h0};
      default: rdWord = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idReg <= RESET_ID;
      arbReg <= RESET_ID;
      rdData <= '0;
    end else begin
      if (strb.wrId) idReg <= busWdata[27:24];
      if (strb.wrArb) arbReg <= busWdata[27:24];
      rdData <= strb.rdEn ? rdWord : '0;
    end
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) routeTable[g] <= '0;
      else if (32'(tIdx) == g) begin
        if (strb.wrLow) begin
          routeTable[g].vector <= busWdata[7:0];
          routeTable[g].mode <= busWdata[10:8];
          routeTable[g].destMode <= busWdata[11];
          routeTable[g].mask <= busWdata[16];
        end
        if (strb.wrHigh) routeTable[g].dest <= busWdata[31:24];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqValid <= 1'b0;
      modeErr <= 1'b0;
      reqVector <= '0;
      reqMode <= '0;
      reqDestMode <= 1'b0;
      reqDest <= '0;
    end else begin
      reqValid <= irqLive && !modeReserved;
      modeErr <= irqLive && modeReserved;
      if (irqLive && !modeReserved) begin
        reqVector <= irqEntry.vector;
        reqMode <= irqEntry.mode;
        reqDestMode <= irqEntry.destMode;
        reqDest <= irqEntry.dest;
      end
    end
  end

  // R10: a masked line yields no request and no error
  assert_masked_silent_R10: assert property (@(posedge clk) disable iff (!rstN)
    irqValid && irqInRange && irqEntry.mask |=> !reqValid && !modeErr);

  // R11: a request never carries a reserved mode
  assert_no_reserved_req_R11: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqMode != 3'd3) && (reqMode != 3'd6));

  // R4: the version select has no write strobe, and the ID holds without its own
  assert_id_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrId |=> $stable(idReg));

  // R12: an out-of-range event produces nothing
  assert_range_R12: assert property (@(posedge clk) disable iff (!rstN)
    irqValid && !irqInRange |=> !reqValid && !modeErr);

endmodule

// File: rtl/irq_route_ctl.sv
module irq_route_ctl
  import irq_route_pkg::*;
#(
  parameter int NUM_LINES = 24,
  parameter logic [3:0] RESET_ID = 4'h2,
  parameter int ADDR_W = 5,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic busValid,
  input  logic busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0] busWdata,
  output logic rdValid,
  output logic [31:0] rdData,
  output logic accessErr,
  output logic decodeErr,
  input  logic irqValid,
  input  logic [IDX_W-1:0] irqIndex,
  output logic reqValid,
  output logic [7:0] reqVector,
  output logic [2:0] reqMode,
  output logic reqDestMode,
  output logic [7:0] reqDest,
  output logic modeErr
);

  ctl_strobe_t strb;
  logic [7:0] selReg;

  irq_route_ctrl #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .selReg(selReg), .strb(strb),
    .rdValid(rdValid), .accessErr(accessErr), .decodeErr(decodeErr)
  );

  irq_route_dp #(.NUM_LINES(NUM_LINES), .RESET_ID(RESET_ID)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .selReg(selReg),
    .busWdata(busWdata), .rdData(rdData), .irqValid(irqValid),
    .irqIndex(irqIndex), .reqValid(reqValid), .reqVector(reqVector),
    .reqMode(reqMode), .reqDestMode(reqDestMode), .reqDest(reqDest),
    .modeErr(modeErr)
  );

endmodule

// File: tb/sim_irq_route_ctl.sv
`timescale 1ns/1ps
module sim_irq_route_ctl;

  localparam int N = 24;
  localparam logic [3:0] RID = 4'h2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busValid = 1'b0, busWrite = 1'b0;
  logic [4:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic rdValid, accessErr, decodeErr, reqValid, reqDestMode, modeErr;
  logic [31:0] rdData;
  logic irqValid = 1'b0;
  logic [4:0] irqIndex = '0;
  logic [7:0] reqVector, reqDest;
  logic [2:0] reqMode;

  int compared = 0, mismatched = 0;
  bit finished = 0;

  logic [7:0] mVec [N];
  logic [2:0] mMode [N];
  logic mDm [N], mMask [N];
  logic [7:0] mDest [N];

  always #2 clk = ~clk;

  irq_route_ctl #(.NUM_LINES(N), .RESET_ID(RID)) u0 (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .rdValid(rdValid),
    .rdData(rdData), .accessErr(accessErr), .decodeErr(decodeErr),
    .irqValid(irqValid), .irqIndex(irqIndex), .reqValid(reqValid),
    .reqVector(reqVector), .reqMode(reqMode), .reqDestMode(reqDestMode),
    .reqDest(reqDest), .modeErr(modeErr)
  );

  function automatic logic [31:0] expLow(int n);
    return {15'h0, mMask[n], 4'h0, mDm[n], mMode[n], mVec[n]};
  endfunction

  function automatic logic [31:0] expHigh(int n);
    return {mDest[n], 24'h0};
  endfunction

  function automatic logic [31:0] verWord();
    return {8'h0, 8'(N - 1), 8'h0, 8'h11};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  logic [31:0] gData;
  logic gRv, gAe, gDe;

  task automatic busOp(bit wr, logic [4:0] addr, logic [31:0] wd);
    @(negedge clk);
    busValid = 1'b1; busWrite = wr; busAddr = addr; busWdata = wd;
    @(posedge clk); #1;
    gData = rdData; gRv = rdValid; gAe = accessErr; gDe = decodeErr;
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic selRead(logic [7:0] sel);
    busOp(1'b1, 5'd0, {24'h0, sel});
    busOp(1'b0, 5'd16, 32'h0);
  endtask

  task automatic selWrite(logic [7:0] sel, logic [31:0] d);
    busOp(1'b1, 5'd0, {24'h0, sel});
    busOp(1'b1, 5'd16, d);
  endtask

  task automatic modelLow(int n, logic [31:0] d);
    mVec[n] = d[7:0]; mMode[n] = d[10:8]; mDm[n] = d[11]; mMask[n] = d[16];
  endtask

  task automatic fire(logic [4:0] idx, string req);
    bit expReq, expErr;
    int n;
    n = int'(idx);
    expReq = 0; expErr = 0;
    if (n < N && !mMask[n]) begin
      if (mMode[n] == 3'd3 || mMode[n] == 3'd6) expErr = 1;
      else expReq = 1;
    end
    @(negedge clk);
    irqValid = 1'b1; irqIndex = idx;
    @(posedge clk); #1;
    check({req, " reqValid"}, {31'h0, reqValid}, {31'h0, expReq});
    check({req, " modeErr"}, {31'h0, modeErr}, {31'h0, expErr});
    if (expReq) begin
      check({req, " fields"}, {5'h0, reqMode, 7'h0, reqDestMode, reqVector, reqDest},
            {5'h0, mMode[n], 7'h0, mDm[n], mVec[n], mDest[n]});
    end
    irqValid = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    compared++; mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin
      mVec[i] = '0; mMode[i] = '0; mDm[i] = 1'b0; mMask[i] = 1'b0; mDest[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R2 reset select, R3/R5 reset IDs, R4 version, R7 entries zero
    busOp(1'b0, 5'd0, 32'h0);
    check("R2 reset select", gData, 32'h0);
    check("R1 rdValid", {31'h0, gRv}, 32'h1);
    busOp(1'b0, 5'd16, 32'h0);
    check("R3 reset id", gData, {4'h0, RID, 24'h0});
    selRead(8'h02); check("R5 reset arb", gData, {4'h0, RID, 24'h0});
    selRead(8'h01); check("R4 version", gData, verWord());
    selRead(8'h10); check("R7 entry0 low", gData, 32'h0);
    selRead(8'h3F); check("R7 entry23 high", gData, 32'h0);

    // R2 select keeps only 8 bits
    busOp(1'b1, 5'd0, 32'hABCDEF12);
    busOp(1'b0, 5'd0, 32'h0);
    check("R2 select readback", gData, 32'h12);

    // R3 id write, R5 arb independent
    selWrite(8'h00, 32'hFFFFFFFF);
    busOp(1'b0, 5'd16, 32'h0); check("R3 id write", gData, 32'h0F000000);
    selRead(8'h02); check("R5 arb unchanged", gData, {4'h0, RID, 24'h0});
    selWrite(8'h02, 32'h5A000000);
    busOp(1'b0, 5'd16, 32'h0); check("R5 arb write", gData, 32'h0A000000);
    selRead(8'h00); check("R3 id after arb write", gData, 32'h0F000000);

    // R4 version ignores writes
    selWrite(8'h01, 32'hFFFFFFFF);
    busOp(1'b0, 5'd16, 32'h0); check("R4 version write ignored", gData, verWord());

    // R6 reserved bits cleared, mapping of last entry
    selWrite(8'h3E, 32'hFFFFFFFF); modelLow(23, 32'hFFFFFFFF);
    busOp(1'b0, 5'd16, 32'h0); check("R6 low reserved zero", gData, 32'h00010FFF);
    selWrite(8'h3F, 32'hFFFFFFFF); mDest[23] = 8'hFF;
    busOp(1'b0, 5'd16, 32'h0); check("R6 high reserved zero", gData, 32'hFF000000);
    selRead(8'h3C); check("R6 neighbour untouched", gData, 32'h0);

    // R8 undefined selects
    selRead(8'h05);
    check("R8 undefined read data", gData, 32'h0);
    check("R8 decodeErr", {31'h0, gDe}, 32'h1);
    selWrite(8'h40, 32'h00000000);
    check("R8 decodeErr write", {31'h0, gDe}, 32'h1);
    selRead(8'h3F); check("R8 write ignored", gData, 32'hFF000000);
    selRead(8'h3E); check("R8 no decodeErr on entry", {31'h0, gDe}, 32'h0);

    // R1 illegal offsets
    busOp(1'b1, 5'd0, 32'h00000010);
    busOp(1'b0, 5'd4, 32'h0);
    check("R1 accessErr", {31'h0, gAe}, 32'h1);
    check("R1 illegal read zero", gData, 32'h0);
    busOp(1'b1, 5'd20, 32'h00000033);
    check("R1 accessErr write", {31'h0, gAe}, 32'h1);
    busOp(1'b0, 5'd0, 32'h0); check("R1 select unchanged", gData, 32'h10);
    check("R1 no accessErr legal", {31'h0, gAe}, 32'h0);

    // R9 each legal mode, both destination modes
    for (int m = 0; m < 8; m++) begin
      logic [31:0] d;
      d = {15'h0, 1'b0, 4'h0, m[0], m[2:0], 8'h40 + 8'(m)};
      selWrite(8'h12, d); modelLow(1, d);
      selWrite(8'h13, {8'(8'h80 >> m), 24'h0}); mDest[1] = 8'h80 >> m;
      if (m == 3 || m == 6) fire(5'd1, "R11 reserved mode");
      else fire(5'd1, "R9 legal mode");
    end
    // R10 masked line, also masked with a reserved mode
    selWrite(8'h14, 32'h00010155); modelLow(2, 32'h00010155);
    fire(5'd2, "R10 masked");
    selWrite(8'h14, 32'h00010355); modelLow(2, 32'h00010355);
    fire(5'd2, "R10 masked reserved");
    // R7 reset entry fires as fixed, vector 0
    fire(5'd7, "R7 zero entry");
    // R12 out of range
    fire(5'd24, "R12 out of range");
    fire(5'd31, "R12 out of range");

    // random mix
    for (int k = 0; k < 400; k++) begin
      int n;
      logic [31:0] r;
      n = int'($urandom_range(N - 1));
      r = $urandom;
      case ($urandom_range(3))
        0: begin selWrite(8'(16 + 2 * n), r); modelLow(n, r); end
        1: begin selWrite(8'(17 + 2 * n), r); mDest[n] = r[31:24]; end
        2: begin
          selRead(8'(16 + 2 * n)); check("R6 random low", gData, expLow(n));
          selRead(8'(17 + 2 * n)); check("R6 random high", gData, expHigh(n));
        end
        default: fire(5'($urandom_range(31)), "R9 random event");
      endcase
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule